// File: doc/BRIEF.md
# Harvard Accumulator Processor with Overlapped Fetch

This block is a small multicycle processor built around one accumulator. Instructions and data sit in two separate internal memories. Each memory has its own address register and data register. A controller steps through micro-states for fetch, decode, load, store, add and the jump family.

An add does its operand access and the fetch of the following instruction in the same three micro-steps. When the add finishes, the next instruction is already in the instruction register. The controller then goes straight to decode and does not fetch again. The program counter still advances exactly once per instruction.

A testbench or a surrounding loader fills both memories through write ports while reset is held. The program then runs until it reaches a halt instruction. A one-cycle retire pulse marks each completed instruction. The program counter, accumulator and flags are visible on the ports, and a combinational peek port reads the data memory.

Top module: `accum_harvard_cpu`

## Requirements
- R1: While `rst_n` is low, at every clock edge the program counter, accumulator and flags are cleared, and `halted_o` and `retire_o` are 0. While `rst_n` is low, a preload write port with its enable set stores its data at its address.
- R2: An instruction is 16 bits, with the opcode in bits 15:12 and the operand address in bits 11:0, of which the low address bits index the memories. A fetch increments the program counter once, so a non-jump instruction that is not an add leaves `pc_o` at its own address plus 1 when it retires.
- R3: Opcode 4 jumps unconditionally. Opcode 5 jumps if the equal flag is set, opcode 6 if the less-than flag is set and opcode 7 if the greater-than flag is set. A taken jump sets `pc_o` to the operand address; an untaken jump falls through.
- R4: Opcode 1 (load) copies data word DM[address] into the accumulator and sets the flags from that value, with overflow cleared.
- R5: Opcode 2 (store) writes the accumulator to DM[address] and leaves the accumulator and flags unchanged.
- R6: Opcode 3 (add) sets the accumulator to accumulator + DM[address], wrapping modulo 2^16. It fetches the following instruction during the same steps. When it retires, `pc_o` equals the add's address plus 2. An add that directly follows an add retires 4 cycles after it.
- R7: `flags_o` bit 0 = accumulator is zero, bit 1 = sign bit set, bit 2 = nonzero with sign bit clear, bit 3 = signed overflow of the latest add. At most one of bits 2:0 is set.
- R8: Opcode F (halt) retires once, raises `halted_o`, and freezes `pc_o` (its address plus 1) and the accumulator. No further retire follows.
- R9: Opcode 0 and the unused opcodes 8 to E change nothing except the program counter.
- R10: `retire_o` pulses for one cycle after each instruction completes, with the outputs already showing its results. For a fetched instruction it comes 4 cycles after the previous pulse for NOP or jumps, 6 for a store and 7 for a load or add. An instruction prefetched by an add comes 3 cycles sooner.
- R11: A preload write while `rst_n` is high has no effect on either memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| im_pre_we | input | 1 | Instruction memory preload enable (honoured in reset) |
| im_pre_addr | input | IAW | Instruction memory preload address |
| im_pre_data | input | 16 | Instruction memory preload word |
| dm_pre_we | input | 1 | Data memory preload enable (honoured in reset) |
| dm_pre_addr | input | DAW | Data memory preload address |
| dm_pre_data | input | DW | Data memory preload word |
| dm_peek_addr | input | DAW | Data memory peek address |
| dm_peek_data | output | DW | Data memory word at the peek address |
| pc_o | output | IAW | Program counter |
| acc_o | output | DW | Accumulator |
| flags_o | output | 4 | {overflow, greater, less, equal} |
| halted_o | output | 1 | Processor has executed a halt |
| retire_o | output | 1 | One-cycle pulse per completed instruction |

## Verification
The assertions assume that every memory location the program touches holds a known value before `rst_n` rises. They also assume that execution reaches a halt instead of running off the end of memory. The stimulus preloads zeros into every instruction and data word during reset, then writes the program and its operands. The program ends in a halt, and a jump goes over each halt that must be skipped. The one preload write made while running targets a zeroed address, so its absence can be seen through the peek port.

// File: rtl/cpu_pkg.sv
// Package: shared encodings for the accumulator processor.
// Assumes a 16-bit instruction word with a 4-bit opcode on top.
package cpu_pkg;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int FIELD_W = INSTR_W - OP_W;

    localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [OP_W-1:0] OP_STORE = 4'h2;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
    localparam logic [OP_W-1:0] OP_JMP   = 4'h4;
    localparam logic [OP_W-1:0] OP_JEQ   = 4'h5;
    localparam logic [OP_W-1:0] OP_JLT   = 4'h6;
    localparam logic [OP_W-1:0] OP_JGT   = 4'h7;
    localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

    typedef enum logic [3:0] {
        ST_F1, ST_F2, ST_F3, ST_DEC,
        ST_L1, ST_L2, ST_L3,
        ST_S1, ST_S2,
        ST_A1, ST_A2, ST_A3,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic ovf;
        logic gt;
        logic lt;
        logic eq;
    } flags_t;
endpackage

// File: rtl/cpu_mem.sv
// Module: cpu_mem
// Word memory with one synchronous write port, one combinational read
// port for the datapath and one combinational peek port.
// Assumes the caller arbitrates between write sources.
module cpu_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Store one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Combinational reads for the datapath and the peek port.
    always_comb begin
        rdata = mem_q[raddr];
        pdata = mem_q[paddr];
    end
endmodule

// File: rtl/cpu_alu.sv
// Module: cpu_alu
// Produces the next accumulator value (loaded word or wrapped sum)
// and the condition flags for it. Purely combinational.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    input  logic          do_add,
    output logic [DW-1:0] result,
    output flags_t        flags
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] sum;
    logic          sum_ovf;

    // Wrapped sum and signed overflow detection.
    always_comb begin
        sum     = acc + operand;
        sum_ovf = (acc[MSB] == operand[MSB]) && (sum[MSB] != acc[MSB]);
    end

    // Select the result and derive the flags from it.
    always_comb begin
        result    = do_add ? sum : operand;
        flags.eq  = (result == '0);
        flags.lt  = result[MSB];
        flags.gt  = (result != '0) && !result[MSB];
        flags.ovf = do_add && sum_ovf;
    end
endmodule

// File: rtl/cpu_ctrl.sv
// Module: cpu_ctrl
// Micro-step sequencer. Runs fetch, decode and the execute steps. After
// an add it returns straight to decode, because the add has already
// fetched the next instruction. Assumes the opcode is stable from decode
// until the instruction completes.
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  flags_t          flags,
    output state_e          state,
    output logic            jump_take,
    output logic            done,
    output logic            halted
);
    state_e state_q, state_d;

    // Next micro-step selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_F1:  state_d = ST_F2;
            ST_F2:  state_d = ST_F3;
            ST_F3:  state_d = ST_DEC;
            ST_DEC: begin
                case (opcode)
                    OP_LOAD:  state_d = ST_L1;
                    OP_STORE: state_d = ST_S1;
                    OP_ADD:   state_d = ST_A1;
                    OP_HALT:  state_d = ST_HALT;
                    default:  state_d = ST_F1;
                endcase
            end
            ST_L1:  state_d = ST_L2;
            ST_L2:  state_d = ST_L3;
            ST_L3:  state_d = ST_F1;
            ST_S1:  state_d = ST_S2;
            ST_S2:  state_d = ST_F1;
            ST_A1:  state_d = ST_A2;
            ST_A2:  state_d = ST_A3;
            ST_A3:  state_d = ST_DEC;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_F1;
        endcase
    end

    // Jump decision and completion strobe.
    always_comb begin
        jump_take = 1'b0;
        if (state_q == ST_DEC) begin
            case (opcode)
                OP_JMP:  jump_take = 1'b1;
                OP_JEQ:  jump_take = flags.eq;
                OP_JLT:  jump_take = flags.lt;
                OP_JGT:  jump_take = flags.gt;
                default: jump_take = 1'b0;
            endcase
        end
        done = (state_q == ST_L3) || (state_q == ST_S2) || (state_q == ST_A3) ||
               ((state_q == ST_DEC) && (opcode != OP_LOAD) &&
                (opcode != OP_STORE) && (opcode != OP_ADD));
    end

    // Micro-step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_F1;
        else        state_q <= state_d;
    end

    assign state  = state_q;
    assign halted = (state_q == ST_HALT);

    // R6: the overlapped add must not re-enter the fetch steps.
    a_r6_add_skips_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_A3) |=> (state_q == ST_DEC));

    // R8: once halted, the sequencer stays halted.
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));
endmodule

// File: rtl/accum_harvard_cpu.sv
// Module: accum_harvard_cpu
// Top level. Holds the datapath registers (PC, IR, accumulator, flags,
// and an address/data register pair per memory), the two memories, the
// ALU and the sequencer. Preload ports write the memories only during
// reset. Assumes IAW and DAW do not exceed the 12-bit address field.
module accum_harvard_cpu
    import cpu_pkg::*;
#(
    parameter int IAW = 8,
    parameter int DAW = 8,
    parameter int DW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               im_pre_we,
    input  logic [IAW-1:0]     im_pre_addr,
    input  logic [INSTR_W-1:0] im_pre_data,
    input  logic               dm_pre_we,
    input  logic [DAW-1:0]     dm_pre_addr,
    input  logic [DW-1:0]      dm_pre_data,
    input  logic [DAW-1:0]     dm_peek_addr,
    output logic [DW-1:0]      dm_peek_data,
    output logic [IAW-1:0]     pc_o,
    output logic [DW-1:0]      acc_o,
    output logic [3:0]         flags_o,
    output logic               halted_o,
    output logic               retire_o
);
    logic [IAW-1:0]     pc_q, mar1_q;
    logic [INSTR_W-1:0] mdr1_q, ir_q;
    logic [DAW-1:0]     mar2_q;
    logic [DW-1:0]      mdr2_q, acc_q;
    flags_t             flags_q;
    logic               retire_q;

    state_e             state;
    logic               jump_take, done, halted;
    logic [INSTR_W-1:0] im_rd, unused_im_peek;
    logic [DW-1:0]      dm_rd;
    logic [DW-1:0]      alu_res;
    flags_t             alu_flags;
    logic               cpu_dm_we;
    logic               unused_ir_bits;

    // Operand address slices of the instruction register.
    logic [IAW-1:0] ir_iaddr;
    logic [DAW-1:0] ir_daddr;
    assign ir_iaddr       = ir_q[IAW-1:0];
    assign ir_daddr       = ir_q[DAW-1:0];
    assign unused_ir_bits = ^ir_q[FIELD_W-1:0];

    // Sequencer.
    cpu_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (ir_q[INSTR_W-1:FIELD_W]),
        .flags     (flags_q),
        .state     (state),
        .jump_take (jump_take),
        .done      (done),
        .halted    (halted)
    );

    // Instruction memory: written only by preload during reset.
    cpu_mem #(.AW(IAW), .DW(INSTR_W)) i_imem (
        .clk   (clk),
        .we    (im_pre_we && !rst_n),
        .waddr (im_pre_addr),
        .wdata (im_pre_data),
        .raddr (mar1_q),
        .rdata (im_rd),
        .paddr ('0),
        .pdata (unused_im_peek)
    );

    // Data memory store strobe from the datapath.
    assign cpu_dm_we = rst_n && (state == ST_S2);

    // Data memory: store from the datapath, preload during reset.
    cpu_mem #(.AW(DAW), .DW(DW)) i_dmem (
        .clk   (clk),
        .we    (cpu_dm_we || (dm_pre_we && !rst_n)),
        .waddr (cpu_dm_we ? mar2_q : dm_pre_addr),
        .wdata (cpu_dm_we ? acc_q  : dm_pre_data),
        .raddr (mar2_q),
        .rdata (dm_rd),
        .paddr (dm_peek_addr),
        .pdata (dm_peek_data)
    );

    // Load or add result and flags.
    cpu_alu #(.DW(DW)) i_alu (
        .acc     (acc_q),
        .operand (mdr2_q),
        .do_add  (state == ST_A3),
        .result  (alu_res),
        .flags   (alu_flags)
    );

    // Datapath register transfers, one group per micro-step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            mar1_q   <= '0;
            mdr1_q   <= '0;
            ir_q     <= '0;
            mar2_q   <= '0;
            mdr2_q   <= '0;
            acc_q    <= '0;
            flags_q  <= '0;
            retire_q <= 1'b0;
        end else begin
            retire_q <= done;
            case (state)
                ST_F1: mar1_q <= pc_q;
                ST_F2: begin
                    mdr1_q <= im_rd;
                    pc_q   <= pc_q + IAW'(1);
                end
                ST_F3: ir_q <= mdr1_q;
                ST_DEC: if (jump_take) pc_q <= ir_iaddr;
                ST_L1, ST_S1: mar2_q <= ir_daddr;
                ST_L2: mdr2_q <= dm_rd;
                ST_L3: begin
                    acc_q   <= alu_res;
                    flags_q <= alu_flags;
                end
                ST_A1: begin
                    mar2_q <= ir_daddr;
                    mar1_q <= pc_q;
                end
                ST_A2: begin
                    mdr2_q <= dm_rd;
                    mdr1_q <= im_rd;
                    pc_q   <= pc_q + IAW'(1);
                end
                ST_A3: begin
                    acc_q   <= alu_res;
                    flags_q <= alu_flags;
                    ir_q    <= mdr1_q;
                end
                default: ;
            endcase
        end
    end

    assign pc_o     = pc_q;
    assign acc_o    = acc_q;
    assign flags_o  = flags_q;
    assign halted_o = halted;
    assign retire_o = retire_q;

    // R2: the fetch read step advances the PC by exactly one.
    a_r2_fetch_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F2) |=> (pc_q == $past(pc_q) + IAW'(1)));

    // R3: a taken jump lands on the operand address.
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        jump_take |=> (pc_q == $past(ir_iaddr)));

    // R4: a load leaves the fetched data word in the accumulator.
    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L3) |=> (acc_q == $past(mdr2_q)));

    // R5: after a store the addressed data word holds the accumulator.
    a_r5_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S2) |=> (dm_rd == $past(acc_q)));

    // R7: the sign-class flags are mutually exclusive.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_q.gt, flags_q.lt, flags_q.eq}));

    // R8: a halted processor keeps its PC and accumulator.
    a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_q) && $stable(acc_q)));
endmodule

// File: tb/test_accum_harvard_cpu.sv
`timescale 1ns/1ps
// Scoreboard bench: a reference model run by the driver pushes one
// expected item per instruction; the monitor pops on each retire pulse.
module test_accum_harvard_cpu;
    localparam int IAW = 8;
    localparam int DAW = 8;
    localparam int DW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            im_pre_we = 1'b0;
    logic [IAW-1:0]  im_pre_addr = '0;
    logic [15:0]     im_pre_data = '0;
    logic            dm_pre_we = 1'b0;
    logic [DAW-1:0]  dm_pre_addr = '0;
    logic [DW-1:0]   dm_pre_data = '0;
    logic [DAW-1:0]  dm_peek_addr = '0;
    logic [DW-1:0]   dm_peek_data;
    logic [IAW-1:0]  pc_o;
    logic [DW-1:0]   acc_o;
    logic [3:0]      flags_o;
    logic            halted_o, retire_o;

    accum_harvard_cpu #(.IAW(IAW), .DAW(DAW), .DW(DW)) i_accum_harvard_cpu (.*);

    always #2 clk = ~clk;

    typedef struct {
        int unsigned pc;
        int unsigned acc;
        int unsigned fl;
        int unsigned halted;
        int          gap;
        int unsigned op;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          last_ret = 0;
    bit          finished = 0;
    logic [15:0] im_m [256];
    logic [15:0] dm_m [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
        return {op, a};
    endfunction

    function automatic logic [3:0] mk_flags(logic [15:0] v, logic ovf);
        return {ovf, (v != 0) && !v[15], v[15], v == 0};
    endfunction

    task automatic put_im(int a, logic [15:0] w);
        im_m[a] = w;
        @(negedge clk);
        im_pre_we = 1'b1; im_pre_addr = IAW'(a); im_pre_data = w;
        @(negedge clk);
        im_pre_we = 1'b0;
    endtask

    task automatic put_dm(int a, logic [15:0] w);
        dm_m[a] = w;
        @(negedge clk);
        dm_pre_we = 1'b1; dm_pre_addr = DAW'(a); dm_pre_data = w;
        @(negedge clk);
        dm_pre_we = 1'b0;
    endtask

    // Driver side: independent reference model fills the scoreboard.
    task automatic run_model();
        int unsigned pc = 0, nx, base;
        logic [15:0] acc = 0, w, s;
        logic [3:0]  fl = 0;
        logic [3:0]  op;
        logic [7:0]  a;
        bit          prev_add = 0, first = 1;
        exp_t        it;
        for (int step = 0; step < 200; step++) begin
            w = im_m[pc]; op = w[15:12]; a = w[7:0];
            nx = (pc + 1) % 256; base = 4;
            case (op)
                4'h1: begin acc = dm_m[a]; fl = mk_flags(acc, 1'b0); base = 7; end
                4'h2: begin dm_m[a] = acc; base = 6; end
                4'h3: begin
                    s = acc + dm_m[a];
                    fl = mk_flags(s, (acc[15] == dm_m[a][15]) && (s[15] != acc[15]));
                    acc = s; base = 7;
                end
                4'h4: nx = a;
                4'h5: if (fl[0]) nx = a;
                4'h6: if (fl[1]) nx = a;
                4'h7: if (fl[2]) nx = a;
                default: ;
            endcase
            it.pc = (op == 4'h3) ? (nx + 1) % 256 : nx;
            it.acc = acc; it.fl = fl; it.halted = (op == 4'hF);
            it.gap = first ? 0 : (prev_add ? base - 3 : base);
            it.op = op;
            sb_q.push_back(it);
            first = 0; prev_add = (op == 4'h3); pc = nx;
            if (op == 4'hF) break;
        end
    endtask

    function automatic string req_of(int unsigned op);
        case (op)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5, 6, 7: return "R3";
            15: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Monitor side: compare each retired instruction with the model.
    always @(negedge clk) begin
        if (rst_n && retire_o) begin
            if (sb_q.size() == 0) begin
                chk("R10", "unexpected retire", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(req_of(e.op), "pc", pc_o, e.pc);
                chk(req_of(e.op), "acc", acc_o, e.acc);
                chk("R7", "flags", flags_o, e.fl);
                chk("R8", "halted", halted_o, e.halted);
                if (e.gap != 0)
                    chk((e.op == 3) ? "R6" : "R10", "retire gap", cyc - last_ret, e.gap);
            end
            last_ret = cyc;
        end
    end

    initial begin
        int n;
        logic [IAW-1:0] hpc;
        logic [DW-1:0]  hacc;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            im_m[i] = '0; dm_m[i] = '0;
            im_pre_we = 1'b1; im_pre_addr = IAW'(i); im_pre_data = '0;
            dm_pre_we = 1'b1; dm_pre_addr = DAW'(i); dm_pre_data = '0;
            @(negedge clk);
        end
        im_pre_we = 1'b0; dm_pre_we = 1'b0;
        put_dm(8'h10, 16'h0005); put_dm(8'h11, 16'h0007);
        put_dm(8'h12, 16'h7FFF); put_dm(8'h13, 16'hFFFF);
        put_dm(8'h14, 16'h0000);
        put_im(0,  ins(4'h1, 12'h010));
        put_im(1,  ins(4'h3, 12'h011));
        put_im(2,  ins(4'h3, 12'h012));
        put_im(3,  ins(4'h2, 12'h020));
        put_im(4,  ins(4'h3, 12'h013));
        put_im(5,  ins(4'h6, 12'h008));
        put_im(6,  ins(4'hF, 12'h000));
        put_im(8,  ins(4'h1, 12'h014));
        put_im(9,  ins(4'h5, 12'h00C));
        put_im(10, ins(4'hF, 12'h000));
        put_im(12, ins(4'h7, 12'h000));
        put_im(13, ins(4'h9, 12'h0AB));
        put_im(14, ins(4'h2, 12'h021));
        put_im(15, ins(4'h1, 12'h011));
        put_im(16, ins(4'h7, 12'h012));
        put_im(17, ins(4'hF, 12'h000));
        put_im(18, ins(4'h6, 12'h000));
        put_im(19, ins(4'h5, 12'h000));
        put_im(20, ins(4'h4, 12'h016));
        put_im(21, ins(4'hF, 12'h000));
        put_im(22, ins(4'h3, 12'h013));
        put_im(23, ins(4'h3, 12'h013));
        put_im(24, ins(4'h0, 12'h000));
        put_im(25, ins(4'hF, 12'h000));

        // R1: reset state and preload visible through the peek port.
        @(negedge clk);
        chk("R1", "pc in reset", pc_o, 0);
        chk("R1", "acc in reset", acc_o, 0);
        chk("R1", "flags in reset", flags_o, 0);
        chk("R1", "halted in reset", halted_o, 0);
        chk("R1", "retire in reset", retire_o, 0);
        dm_peek_addr = 8'h12;
        #0.1;
        chk("R1", "preloaded word", dm_peek_data, 16'h7FFF);

        run_model();
        rst_n = 1'b1;
        last_ret = cyc;

        // R11: a preload write while running is ignored.
        repeat (10) @(negedge clk);
        dm_pre_we = 1'b1; dm_pre_addr = 8'h30; dm_pre_data = 16'hABCD;
        im_pre_we = 1'b1; im_pre_addr = 8'd26; im_pre_data = 16'h1234;
        @(negedge clk);
        dm_pre_we = 1'b0; im_pre_we = 1'b0;

        n = 0;
        while (!halted_o && n < 5000) begin @(negedge clk); n++; end
        chk("R8", "halt reached", halted_o, 1);
        hpc = pc_o; hacc = acc_o;
        repeat (20) @(negedge clk);
        chk("R8", "pc frozen", pc_o, hpc);
        chk("R8", "acc frozen", acc_o, hacc);
        chk("R10", "scoreboard drained", sb_q.size(), 0);

        dm_peek_addr = 8'h20; #0.1;
        chk("R5", "stored overflowed sum", dm_peek_data, dm_m[8'h20]);
        dm_peek_addr = 8'h21; #0.1;
        chk("R5", "stored zero", dm_peek_data, dm_m[8'h21]);
        dm_peek_addr = 8'h30; #0.1;
        chk("R11", "running preload ignored", dm_peek_data, 0);
        dm_peek_addr = 8'h10; #0.1;
        chk("R9", "operand word untouched", dm_peek_data, 16'h0005);

        // R1: reset after a run clears the architectural state.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "pc after reset", pc_o, 0);
        chk("R1", "acc after reset", acc_o, 0);
        chk("R1", "flags after reset", flags_o, 0);
        chk("R1", "halted after reset", halted_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule